// File: doc/BRIEF.md
# Completion Signal Updater

This block closes out executed descriptors. Each finished descriptor hands it a result: the byte address of a 64-bit completion counter in memory, a pass/fail flag with a status code, and a flag asking for an interrupt. The block performs a read-modify-write on that counter. On success it lowers the counter by one. On failure it stamps an all-ones error signature into the counter and puts the status code into the following 64-bit word.

Software loads the counter with the number of descriptors in a group before it submits them. It can then poll until the counter reaches zero, or wait for an interrupt. Several descriptors may share one counter. For that reason only one read-modify-write is in flight at any time: the next read is not issued until the previous write is acknowledged, so no decrement is lost. Once the signature is in place, later successes leave it alone, so the error stays visible to software.

Top module: `cmpl_sig_updater`

## Requirements
- R1: Results are accepted when `in_valid` and `in_ready` are both high, and are processed strictly in arrival order. A queue of DEPTH entries sits behind the sequencer, which holds one result of its own. With the read port stalled, DEPTH+1 results are therefore accepted before `in_ready` drops. When two failures hit the same counter, the later status code is the one left in memory.
- R2: For every result, the 64-bit word at `in_addr` is fetched over the read port before any write for that result is issued.
- R3: On success, when the fetched value is neither all ones nor zero, the value minus one is written back to `in_addr`. A fetched zero is written back as zero.
- R4: On failure, all ones is written to `in_addr`. After that write is acknowledged, the status code, zero-extended to 64 bits, is written to `in_addr + 8`.
- R5: On success, when the fetched value is all ones (the error signature), no write is issued and the signature stays in memory.
- R6: No read is issued and no write is presented while an earlier read or write is still outstanding. N successes on one counter initialised to V therefore leave exactly max(V−N, 0).
- R7: `irq` pulses high for one cycle once per result that asked for it, and only after the last write of that result has been acknowledged, or after the read data arrives when no write is needed. Results that did not ask for it never raise `irq`.
- R8: Once `rd_valid` or `wr_valid` is raised, it stays high with its address (and write data) unchanged until the matching ready is seen.
- R9: During reset, `in_ready` is high and `rd_valid`, `wr_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Completion result offered |
| in_ready | output | 1 | Queue can take a result |
| in_addr | input | AW | Byte address of the 64-bit counter |
| in_fail | input | 1 | Descriptor failed |
| in_code | input | CW | Status code stored on failure |
| in_irq | input | 1 | Request an interrupt on completion |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | AW | Read byte address |
| rdata_valid | input | 1 | Read data returned |
| rdata | input | 64 | Read data |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 64 | Write data |
| wr_ack | input | 1 | Write committed |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check on every cycle the properties of a single transaction. Requests hold stable until they are accepted. No read or write starts while another access is outstanding. Every write back to the counter just read is either the correct saturating decrement or the signature. An interrupt never fires with a write still unacknowledged. What only the bench's scenarios can show is the end state in memory. It sweeps group sizes, error positions and interrupt masks to show that a shared counter ends at the right value or the signature, that the status word holds the latest failure code, that interrupts arrive once per request, and how deep the queue really is.

// File: rtl/cmpl_sig_updater.sv
module cmpl_sig_updater #(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_fail,
  input  logic [CW-1:0] in_code,
  input  logic          in_irq,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rdata_valid,
  input  logic [63:0]   rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  input  logic          wr_ack,
  output logic          irq
);
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = AW + CW + 2;
  localparam logic [63:0] SIG = '1;
  localparam logic [AW-1:0] NEXT_WORD = AW'(8);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RW, S_W0, S_A0, S_W1, S_A1, S_IRQ} st_t;

  logic [EW-1:0] q [DEPTH];
  logic [QW:0]   wp, rp;
  logic          empty, full, push;
  st_t           st;
  logic [AW-1:0] h_addr, w_addr;
  logic [CW-1:0] h_code;
  logic          h_fail, h_irq;
  logic [63:0]   w_data;
  logic [EW-1:0] head;

  assign empty    = (wp == rp);
  assign full     = (wp[QW] != rp[QW]) && (wp[QW-1:0] == rp[QW-1:0]);
  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign head     = q[rp[QW-1:0]];

  always_ff @(posedge clk) begin
    if (push) q[wp[QW-1:0]] <= {in_addr, in_code, in_fail, in_irq};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
    end else if (push) begin
      wp <= wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rp     <= '0;
      h_addr <= '0;
      h_code <= '0;
      h_fail <= 1'b0;
      h_irq  <= 1'b0;
      w_addr <= '0;
      w_data <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (!empty) begin
          {h_addr, h_code, h_fail, h_irq} <= head;
          rp <= rp + 1'b1;
          st <= S_RD;
        end
        S_RD: if (rd_ready) st <= S_RW;
        S_RW: if (rdata_valid) begin
          w_addr <= h_addr;
          if (h_fail) begin
            w_data <= SIG;
            st     <= S_W0;
          end else if (rdata == SIG) begin
            st <= S_IRQ;
          end else begin
            w_data <= (rdata == 64'd0) ? 64'd0 : rdata - 64'd1;
            st     <= S_W0;
          end
        end
        S_W0: if (wr_ready) st <= S_A0;
        S_A0: if (wr_ack) begin
          if (h_fail) begin
            w_addr <= h_addr + NEXT_WORD;
            w_data <= 64'(h_code);
            st     <= S_W1;
          end else begin
            st <= S_IRQ;
          end
        end
        S_W1: if (wr_ready) st <= S_A1;
        S_A1: if (wr_ack) st <= S_IRQ;
        S_IRQ: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_valid = (st == S_RD);
  assign rd_addr  = h_addr;
  assign wr_valid = (st == S_W0) || (st == S_W1);
  assign wr_addr  = w_addr;
  assign wr_data  = w_data;
  assign irq      = (st == S_IRQ) && h_irq;
endmodule

module cmpl_sig_updater_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rdata_valid,
  input logic [63:0]   rdata,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [63:0]   wr_data,
  input logic          wr_ack,
  input logic          irq
);
  logic          rd_pend, wr_pend;
  logic [AW-1:0] last_addr;
  logic [63:0]   last_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      wr_pend   <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      if (rd_valid && rd_ready) begin
        rd_pend   <= 1'b1;
        last_addr <= rd_addr;
      end else if (rdata_valid) begin
        rd_pend <= 1'b0;
      end
      if (rdata_valid && rd_pend) last_data <= rdata;
      if (wr_valid && wr_ready) wr_pend <= 1'b1;
      else if (wr_ack) wr_pend <= 1'b0;
    end
  end

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_serial_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_pend && !wr_pend);
  p_serial_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_pend && !wr_pend);
  p_irq_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !wr_pend && !wr_valid && !rd_pend);
  p_sig_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == last_addr && last_data == '1 |-> wr_data == '1);
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == last_addr && wr_data != '1 |->
      wr_data == ((last_data == 64'd0) ? 64'd0 : last_data - 64'd1));
endmodule

bind cmpl_sig_updater cmpl_sig_updater_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .rdata_valid(rdata_valid), .rdata(rdata),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq)
);

// File: tb/cmpl_sig_updater_tb.sv
module cmpl_sig_updater_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_fail = 1'b0, in_irq = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [CW-1:0] in_code = '0;
  logic in_ready, rd_valid, wr_valid, irq;
  logic rd_ready = 1'b0, rdata_valid = 1'b0, wr_ready = 1'b0, wr_ack = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [63:0] rdata = '0, wr_data;

  cmpl_sig_updater #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_fail(in_fail), .in_code(in_code), .in_irq(in_irq),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rdata_valid(rdata_valid), .rdata(rdata), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, irq_seen = 0;
  logic [63:0] mem [32];
  logic hold_rd = 1'b0, rd_pend = 1'b0, ack_pend = 1'b0;
  logic [AW-1:0] rd_a = '0;
  int rd_dly = 0, ack_dly = 0;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (irq) begin
        irq_seen++;
        check(!ack_pend && !wr_valid && !rd_pend, "R7 irq before ack", {62'd0, ack_pend, wr_valid}, 64'd0);
      end
      wr_ack = 1'b0;
      rdata_valid = 1'b0;
      rd_ready = hold_rd ? 1'b0 : (cyc % 3 != 1);
      wr_ready = (cyc % 4 != 2);
      if (rd_pend) begin
        if (rd_dly == 0) begin
          rdata_valid = 1'b1;
          rdata = mem[rd_a[7:3]];
          rd_pend = 1'b0;
        end else rd_dly--;
      end
      if (ack_pend) begin
        if (ack_dly == 0) begin
          wr_ack = 1'b1;
          ack_pend = 1'b0;
        end else ack_dly--;
      end
      if (rd_valid && rd_ready) begin
        rd_pend = 1'b1;
        rd_a = rd_addr;
        rd_dly = cyc % 3;
      end
      if (wr_valid && wr_ready) begin
        mem[wr_addr[7:3]] = wr_data;
        ack_pend = 1'b1;
        ack_dly = cyc % 2;
      end
    end
  end

  task automatic submit(input logic [AW-1:0] a, input logic f, input logic [CW-1:0] c, input logic i);
    in_valid = 1'b1; in_addr = a; in_fail = f; in_code = c; in_irq = i;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 10) begin
      @(negedge clk);
      if (!rd_valid && !wr_valid && !rd_pend && !ack_pend && !rdata_valid && !wr_ack) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    int scen = 0;
    for (int k = 0; k < 32; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    check(in_ready && !rd_valid && !wr_valid && !irq, "R9 reset outputs",
          {60'd0, in_ready, rd_valid, wr_valid, irq}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 1; n <= 4; n++) begin
      for (int e = -1; e < n; e++) begin
        for (int m = 0; m < (1 << n); m++) begin
          int w = (scen % 4) * 2;
          logic [AW-1:0] a = AW'(w * 8);
          logic [63:0] v = 64'(20 + scen);
          logic [63:0] expv;
          int irq0 = irq_seen, nirq = 0;
          logic [CW-1:0] code = CW'(16'h100 + scen);
          mem[w] = v; mem[w+1] = 64'd0;
          for (int j = 0; j < n; j++) begin
            submit(a, (j == e), code, m[j]);
            if (m[j]) nirq++;
          end
          settle();
          expv = (e >= 0) ? '1 : v - 64'(n);
          check(mem[w] == expv, (e >= 0) ? "R4 R5 signature stays" : "R3 R6 group decrement", mem[w], expv);
          if (e >= 0) check(mem[w+1] == 64'(code), "R4 status word", mem[w+1], 64'(code));
          else check(mem[w+1] == 64'd0, "R2 status untouched on success", mem[w+1], 64'd0);
          check(irq_seen - irq0 == nirq, "R7 irq count", 64'(irq_seen - irq0), 64'(nirq));
          scen++;
        end
      end
    end

    mem[0] = 64'd2; mem[2] = 64'd9;
    for (int j = 0; j < 4; j++) begin
      submit(AW'(0), 1'b0, '0, 1'b0);
      submit(AW'(16), 1'b0, '0, 1'b0);
    end
    settle();
    check(mem[0] == 64'd0, "R3 saturate at zero", mem[0], 64'd0);
    check(mem[2] == 64'd5, "R6 interleaved counters", mem[2], 64'd5);

    mem[4] = 64'd7; mem[5] = '0;
    submit(AW'(32), 1'b1, CW'(16'h00AA), 1'b0);
    submit(AW'(32), 1'b1, CW'(16'h00BB), 1'b1);
    settle();
    check(mem[5] == 64'h00BB, "R1 later failure code wins", mem[5], 64'h00BB);
    check(mem[4] == '1, "R4 signature", mem[4], '1);

    hold_rd = 1'b1;
    begin
      int acc = 0;
      for (int j = 0; j < DEPTH + 3; j++) begin
        in_valid = 1'b1; in_addr = AW'(48); in_fail = 1'b0; in_irq = 1'b0;
        if (in_ready) acc++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      check(acc == DEPTH + 1, "R1 queue capacity", 64'(acc), 64'(DEPTH + 1));
      mem[6] = 64'd100;
      hold_rd = 1'b0;
      settle();
      check(mem[6] == 64'(100 - DEPTH - 1), "R1 queued results drain", mem[6], 64'(100 - DEPTH - 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule